// File: doc/BRIEF.md
# Strided Vector Memory Address Generator

This block sends the per-element memory accesses for one vector load or store at a time. A command gives a base word address, a stride, an addressing mode and an element count. In strided mode, element i goes to base + i*stride. Unit stride is the special case where the stride is 1. In indexed mode, element i goes to base + index[i], and each index arrives as one beat on its own stream. Store data arrives on another stream. Load data comes back on a result stream, tagged with its element number.

The memory behind the block is a set of interleaved banks. Word addresses that follow one another land in banks that follow one another. A bank that has just been accessed stays busy for a fixed number of cycles. When the bank for the current element is busy, the block raises `stall` and holds that element. Because of this, the issue rate depends on the stride:
- A stride that is coprime with the bank count issues one element every cycle.
- A stride that shares a factor with the bank count revisits a few banks and slows down.

Every load returns after the same fixed latency, so results always come back in element order.

Streaming rules:
- The command, index and store-data inputs are valid/ready handshakes. A beat moves in a cycle where both valid and ready are high.
- A source must hold valid and its payload stable until the beat is taken. Valid must never wait on ready.
- `idx_ready` and `st_ready` are raised only in the cycle the current element is issued.
- The load-result stream has no ready. The consumer must take every beat.
- `cmd_ready` is high only while the block is idle.
- `done` pulses for one cycle when a command finishes.

Top module: `vec_agen`

## Requirements
- R1: While reset is held and after it is released, `cmd_ready`=1, `rd_valid`=0, `done`=0 and `stall`=0.
- R2: In strided mode (`cmd_indexed`=0), element i accesses word (base + i*stride) mod 2^AW. A stride of all ones therefore walks downward.
- R3: The bank number is address bits [3:0] and the row is bits [7:4]. A bank issued in cycle t accepts its next access no earlier than cycle t+4. With a stride of 16 or 32, loads issue once every 4 cycles.
- R4: A stride that is coprime with 16 issues one element per cycle with no stall. So does a stride of 2 at the default busy time.
- R5: `stall` is high in exactly those cycles where the current element's address is known and its bank is busy. Stride 8 issues in the pattern 2 issued, 2 stalled.
- R6: In indexed mode (`cmd_indexed`=1), element i accesses (base + index[i]) mod 2^AW. `idx_ready` consumes one index beat per issued element, and `stall` applies in the same way as in strided mode.
- R7: Load data appears on `rd_data` exactly 12 cycles after its element issues, in element order, with `rd_elem` = i. When the bank is free, the first element issues in the cycle after the command is accepted.
- R8: A `cmd_vlen` above 64 is treated as 64. A `cmd_vlen` of 0 makes no access and pulses `done` in the cycle after acceptance.
- R9: `done` pulses for one cycle. For a load, this is the cycle after the last result beat. For a store, it is the cycle after the last data beat is accepted. `cmd_ready` stays low from acceptance until that pulse.
- R10: A store (`cmd_store`=1) writes `st_data` to the element's address. Without `st_valid` the element is held, nothing is written, `st_ready` stays 0 and `done` does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and accepting a command |
| cmd_indexed | input | 1 | 1 = indexed addressing, 0 = strided |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_base | input | AW | Base word address |
| cmd_stride | input | AW | Stride in words (modular) |
| cmd_vlen | input | VLW | Element count, clamped to MAXVL |
| idx_valid | input | 1 | Index beat offered |
| idx_ready | output | 1 | Index beat consumed by the issuing element |
| idx_data | input | AW | Index offset |
| st_valid | input | 1 | Store data beat offered |
| st_ready | output | 1 | Store data consumed by the issuing element |
| st_data | input | DW | Store data |
| rd_valid | output | 1 | Load result beat |
| rd_elem | output | EW | Element number of the result |
| rd_data | output | DW | Loaded word |
| stall | output | 1 | Current element held on a busy bank |
| done | output | 1 | Command finished (one-cycle pulse) |

## Verification
The bench uses the default parameters: 16 banks of 16 rows, 32-bit words, a busy time of 4, a latency of 12 and a maximum length of 64. The 256-word space is small enough to preload with four full-length unit-stride stores. In a space this size, addresses wrap at 255, so a stride of all ones walks downward. With 16 banks and a busy time of 4, strides 8, 16 and 32 give three distinct stall patterns whose stall counts and completion cycles can be worked out by hand. Strides 1, 2, 3 and 5 must run without a stall. The length clamp at 64 is reachable with a single command.

// File: rtl/vagen_pkg.sv
package vagen_pkg;
  typedef enum logic [1:0] {
    AG_IDLE  = 2'd0,
    AG_ISSUE = 2'd1,
    AG_DRAIN = 2'd2
  } ag_state_e;
endpackage

// File: rtl/vagen_bank_busy.sv
// One countdown per bank: loaded on access, free again when it reaches zero.
module vagen_bank_busy #(
  parameter int NBANK = 16,
  parameter int BUSY  = 4,
  localparam int BB   = $clog2(NBANK),
  localparam int CW   = $clog2(BUSY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_fire,
  input  logic [BB-1:0]    acc_bank,
  output logic [NBANK-1:0] bank_busy
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [CW-1:0] left_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        left_q <= '0;
      end else if (acc_fire && acc_bank == BB'(b)) begin
        left_q <= CW'(BUSY - 1);
      end else if (left_q != '0) begin
        left_q <= left_q - CW'(1);
      end
    end
    assign bank_busy[b] = (left_q != '0);
  end
endmodule

// File: rtl/vagen_seq.sv
// Command capture, element walk, address formation and issue decision.
module vagen_seq
  import vagen_pkg::*;
#(
  parameter int NBANK = 16,
  parameter int AW    = 8,
  parameter int VLW   = 7,
  parameter int EW    = 6,
  parameter int MAXVL = 64,
  localparam int BB   = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_indexed,
  input  logic             cmd_store,
  input  logic [AW-1:0]    cmd_base,
  input  logic [AW-1:0]    cmd_stride,
  input  logic [VLW-1:0]   cmd_vlen,
  input  logic             idx_valid,
  output logic             idx_ready,
  input  logic [AW-1:0]    idx_data,
  input  logic             st_valid,
  output logic             st_ready,
  input  logic [NBANK-1:0] bank_busy,
  input  logic             ret_valid,
  input  logic             ret_last,
  output logic             acc_fire,
  output logic [AW-1:0]    acc_addr,
  output logic [EW-1:0]    acc_elem,
  output logic             acc_last,
  output logic             acc_store,
  output logic             stall,
  output logic             done
);
  ag_state_e      state_q;
  logic [VLW-1:0] len_q, cnt_q, len_in;
  logic [AW-1:0]  base_q, stride_q, walk_q, addr;
  logic           idx_mode_q, store_q, done_q;
  logic           accept, addr_known, data_ok, bank_free, fire, last;
  logic [BB-1:0]  bank;

  always_comb begin
    len_in     = (cmd_vlen > VLW'(MAXVL)) ? VLW'(MAXVL) : cmd_vlen;
    cmd_ready  = (state_q == AG_IDLE);
    accept     = cmd_valid && cmd_ready;
    addr       = idx_mode_q ? (base_q + idx_data) : walk_q;
    bank       = addr[BB-1:0];
    addr_known = !idx_mode_q || idx_valid;
    data_ok    = addr_known && (!store_q || st_valid);
    bank_free  = !bank_busy[bank];
    fire       = (state_q == AG_ISSUE) && data_ok && bank_free;
    stall      = (state_q == AG_ISSUE) && addr_known && !bank_free;
    last       = (cnt_q == len_q - VLW'(1));
  end

  assign idx_ready = fire && idx_mode_q;
  assign st_ready  = fire && store_q;
  assign acc_fire  = fire;
  assign acc_addr  = addr;
  assign acc_elem  = cnt_q[EW-1:0];
  assign acc_last  = last;
  assign acc_store = store_q;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= AG_IDLE;
      len_q      <= '0;
      cnt_q      <= '0;
      base_q     <= '0;
      stride_q   <= '0;
      walk_q     <= '0;
      idx_mode_q <= 1'b0;
      store_q    <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        AG_IDLE: begin
          if (accept) begin
            base_q     <= cmd_base;
            stride_q   <= cmd_stride;
            walk_q     <= cmd_base;
            idx_mode_q <= cmd_indexed;
            store_q    <= cmd_store;
            len_q      <= len_in;
            cnt_q      <= '0;
            if (len_in == '0) done_q  <= 1'b1;
            else              state_q <= AG_ISSUE;
          end
        end
        AG_ISSUE: begin
          if (fire) begin
            cnt_q  <= cnt_q + VLW'(1);
            walk_q <= walk_q + stride_q;
            if (last) begin
              if (store_q) begin
                state_q <= AG_IDLE;
                done_q  <= 1'b1;
              end else begin
                state_q <= AG_DRAIN;
              end
            end
          end
        end
        AG_DRAIN: begin
          if (ret_valid && ret_last) begin
            state_q <= AG_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= AG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vagen_bank_mem.sv
// Interleaved storage plus a fixed-depth return pipeline for load results.
module vagen_bank_mem #(
  parameter int NBANK = 16,
  parameter int ROWS  = 16,
  parameter int DW    = 32,
  parameter int LAT   = 12,
  parameter int EW    = 6,
  localparam int BB   = $clog2(NBANK),
  localparam int RB   = $clog2(ROWS),
  localparam int AW   = BB + RB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_fire,
  input  logic          acc_store,
  input  logic [AW-1:0] acc_addr,
  input  logic [EW-1:0] acc_elem,
  input  logic          acc_last,
  input  logic [DW-1:0] wdata,
  output logic          ret_valid,
  output logic          ret_last,
  output logic [EW-1:0] ret_elem,
  output logic [DW-1:0] ret_data
);
  logic [BB-1:0]             bank;
  logic [RB-1:0]             row;
  logic [NBANK-1:0][DW-1:0]  bank_word;

  assign bank = acc_addr[BB-1:0];
  assign row  = acc_addr[BB +: RB];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0] cells [ROWS];
    always_ff @(posedge clk) begin
      if (acc_fire && acc_store && bank == BB'(b)) cells[row] <= wdata;
    end
    assign bank_word[b] = cells[row];
  end

  logic [LAT-1:0]          pv, pl;
  logic [LAT-1:0][EW-1:0]  pe;
  logic [LAT-1:0][DW-1:0]  pd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= '0;
    end else begin
      pv[0] <= acc_fire && !acc_store;
      for (int s = 1; s < LAT; s++) pv[s] <= pv[s-1];
    end
  end

  always_ff @(posedge clk) begin
    pl[0] <= acc_last;
    pe[0] <= acc_elem;
    pd[0] <= bank_word[bank];
    for (int s = 1; s < LAT; s++) begin
      pl[s] <= pl[s-1];
      pe[s] <= pe[s-1];
      pd[s] <= pd[s-1];
    end
  end

  assign ret_valid = pv[LAT-1];
  assign ret_last  = pl[LAT-1];
  assign ret_elem  = pe[LAT-1];
  assign ret_data  = pd[LAT-1];
endmodule

// File: rtl/vec_agen.sv
module vec_agen #(
  parameter int NBANK = 16,
  parameter int ROWS  = 16,
  parameter int DW    = 32,
  parameter int BUSY  = 4,
  parameter int LAT   = 12,
  parameter int MAXVL = 64,
  localparam int BB   = $clog2(NBANK),
  localparam int AW   = BB + $clog2(ROWS),
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int EW   = $clog2(MAXVL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic           cmd_indexed,
  input  logic           cmd_store,
  input  logic [AW-1:0]  cmd_base,
  input  logic [AW-1:0]  cmd_stride,
  input  logic [VLW-1:0] cmd_vlen,
  input  logic           idx_valid,
  output logic           idx_ready,
  input  logic [AW-1:0]  idx_data,
  input  logic           st_valid,
  output logic           st_ready,
  input  logic [DW-1:0]  st_data,
  output logic           rd_valid,
  output logic [EW-1:0]  rd_elem,
  output logic [DW-1:0]  rd_data,
  output logic           stall,
  output logic           done
);
  logic             acc_fire, acc_last, acc_store, ret_last;
  logic [AW-1:0]    acc_addr;
  logic [EW-1:0]    acc_elem;
  logic [BB-1:0]    acc_bank;
  logic [NBANK-1:0] bank_busy;

  assign acc_bank = acc_addr[BB-1:0];

  vagen_seq #(
    .NBANK(NBANK), .AW(AW), .VLW(VLW), .EW(EW), .MAXVL(MAXVL)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_indexed(cmd_indexed), .cmd_store(cmd_store),
    .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_vlen(cmd_vlen),
    .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_data(idx_data),
    .st_valid(st_valid), .st_ready(st_ready),
    .bank_busy(bank_busy),
    .ret_valid(rd_valid), .ret_last(ret_last),
    .acc_fire(acc_fire), .acc_addr(acc_addr), .acc_elem(acc_elem),
    .acc_last(acc_last), .acc_store(acc_store),
    .stall(stall), .done(done)
  );

  vagen_bank_busy #(.NBANK(NBANK), .BUSY(BUSY)) u_busy (
    .clk(clk), .rst_n(rst_n),
    .acc_fire(acc_fire), .acc_bank(acc_bank),
    .bank_busy(bank_busy)
  );

  vagen_bank_mem #(
    .NBANK(NBANK), .ROWS(ROWS), .DW(DW), .LAT(LAT), .EW(EW)
  ) u_mem (
    .clk(clk), .rst_n(rst_n),
    .acc_fire(acc_fire), .acc_store(acc_store), .acc_addr(acc_addr),
    .acc_elem(acc_elem), .acc_last(acc_last), .wdata(st_data),
    .ret_valid(rd_valid), .ret_last(ret_last),
    .ret_elem(rd_elem), .ret_data(rd_data)
  );
endmodule

// File: rtl/vagen_chk.sv
module vagen_chk #(
  parameter int NBANK = 16,
  parameter int BUSY  = 4,
  parameter int VLW   = 7,
  localparam int BB   = $clog2(NBANK),
  localparam int CW   = $clog2(BUSY + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           acc_fire,
  input logic [BB-1:0]  acc_bank,
  input logic           stall,
  input logic           st_valid,
  input logic           st_ready,
  input logic           idx_valid,
  input logic           idx_ready,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic [VLW-1:0] cmd_vlen,
  input logic           done,
  input logic           rd_valid
);
  // Cycles since each bank's last access, saturating at BUSY.
  logic [NBANK-1:0][CW-1:0] age_q;
  for (genvar b = 0; b < NBANK; b++) begin : g_age
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              age_q[b] <= CW'(BUSY);
      else if (acc_fire && acc_bank == BB'(b)) age_q[b] <= CW'(1);
      else if (age_q[b] < CW'(BUSY))           age_q[b] <= age_q[b] + CW'(1);
    end
  end

  // R3
  bank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |-> age_q[acc_bank] >= CW'(BUSY));
  // R5
  stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !acc_fire);
  // R10
  st_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready |-> st_valid);
  // R6
  idx_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ready |-> idx_valid);
  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_vlen == '0) |=> done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
  // R9
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cmd_ready);
endmodule

bind vec_agen vagen_chk #(.NBANK(NBANK), .BUSY(BUSY), .VLW(VLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_fire(acc_fire), .acc_bank(acc_bank),
  .stall(stall), .st_valid(st_valid), .st_ready(st_ready),
  .idx_valid(idx_valid), .idx_ready(idx_ready),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_vlen(cmd_vlen),
  .done(done), .rd_valid(rd_valid)
);

// File: tb/sim_vec_agen.sv
`timescale 1ns/100ps
module sim_vec_agen;
  localparam int AW = 8, DW = 32, VLW = 7, EW = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n, cmd_valid, cmd_ready, cmd_indexed, cmd_store;
  logic [AW-1:0]  cmd_base, cmd_stride, idx_data;
  logic [VLW-1:0] cmd_vlen;
  logic           idx_valid, idx_ready, st_valid, st_ready;
  logic [DW-1:0]  st_data, rd_data;
  logic           rd_valid, stall, done;
  logic [EW-1:0]  rd_elem;

  vec_agen u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_indexed(cmd_indexed), .cmd_store(cmd_store), .cmd_base(cmd_base),
    .cmd_stride(cmd_stride), .cmd_vlen(cmd_vlen), .idx_valid(idx_valid),
    .idx_ready(idx_ready), .idx_data(idx_data), .st_valid(st_valid),
    .st_ready(st_ready), .st_data(st_data), .rd_valid(rd_valid),
    .rd_elem(rd_elem), .rd_data(rd_data), .stall(stall), .done(done)
  );

  int checks = 0, fails = 0;
  logic [DW-1:0] exp_mem [256];
  int idx_list [8];

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {8'hC3, a, ~a, a ^ 8'h5A};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // base, stride, vlen, cycles from accept to done, stall cycles
  typedef struct packed {
    logic [7:0] base; logic [7:0] stride; logic [7:0] vlen;
    logic [7:0] tot;  logic [7:0] stalls;
  } lcase_t;
  localparam lcase_t LTAB [9] = '{
    '{8'd100, 8'd1,   8'd16,  8'd29, 8'd0},   // R4 unit stride
    '{8'd1,   8'd3,   8'd20,  8'd33, 8'd0},   // R4 coprime stride
    '{8'd5,   8'd16,  8'd8,   8'd42, 8'd21},  // R3 single bank
    '{8'd0,   8'd8,   8'd8,   8'd27, 8'd6},   // R5 two banks
    '{8'd7,   8'd32,  8'd4,   8'd26, 8'd9},   // R3 single bank, row skip
    '{8'd3,   8'd2,   8'd12,  8'd25, 8'd0},   // R4 eight banks
    '{8'd250, 8'd5,   8'd10,  8'd23, 8'd0},   // R2 address wrap
    '{8'd20,  8'd255, 8'd8,   8'd21, 8'd0},   // R2 descending
    '{8'd0,   8'd1,   8'd100, 8'd77, 8'd0}    // R8 clamp to 64
  };

  task automatic send_cmd(input bit ind, input bit st, input int base,
                          input int stride, input int vlen);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_indexed = ind; cmd_store = st;
    cmd_base = AW'(base); cmd_stride = AW'(stride); cmd_vlen = VLW'(vlen);
    #1;
    chk(cmd_ready, "R9 cmd_ready when idle", 64'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_load(input bit ind, input int base, input int stride,
                         input int vlen, input int exp_tot, input int exp_stall);
    int n, k, got, stalls, done_k, first_k;
    n = (vlen > 64) ? 64 : vlen;
    send_cmd(ind, 1'b0, base, stride, vlen);
    k = 1; got = 0; stalls = 0; done_k = 0; first_k = 0;
    fork
      begin
        if (ind) begin
          int c;
          c = 0;
          while (c < n) begin
            idx_valid = 1'b1; idx_data = AW'(idx_list[c]);
            #1;
            if (idx_ready) c++;
            @(negedge clk);
          end
          idx_valid = 1'b0;
        end
      end
      begin
        while (done_k == 0 && k < 400) begin
          #2;
          if (k == 1 && n > 0)
            chk(!cmd_ready, "R9 busy after accept", 64'(cmd_ready), 0);
          if (stall) stalls++;
          if (rd_valid) begin
            logic [AW-1:0] ea;
            ea = ind ? AW'((base + idx_list[got]) & 255)
                     : AW'((base + got * stride) & 255);
            if (got == 0) first_k = k;
            chk(rd_elem == EW'(got), "R7 element order", 64'(rd_elem), 64'(got));
            chk(rd_data == exp_mem[ea], ind ? "R6 indexed data" : "R2 strided data",
                64'(rd_data), 64'(exp_mem[ea]));
            got++;
          end
          if (done) done_k = k;
          else begin
            k++;
            @(negedge clk);
          end
        end
      end
    join
    chk(done_k == exp_tot, "R9 done cycle (R3/R4/R5 issue timing)", 64'(done_k), 64'(exp_tot));
    chk(got == n, "R8 result count", 64'(got), 64'(n));
    chk(stalls == exp_stall, "R5 stall cycles", 64'(stalls), 64'(exp_stall));
    if (n > 0) chk(first_k == 13, "R7 first result latency", 64'(first_k), 13);
  endtask

  task automatic do_store(input int base, input int stride, input int vlen,
                          input int hold, input bit alt, input int exp_tot);
    int k, c, done_k;
    logic [AW-1:0] ea;
    send_cmd(1'b0, 1'b1, base, stride, vlen);
    k = 1; c = 0; done_k = 0;
    while (done_k == 0 && k < 400) begin
      ea = AW'((base + c * stride) & 255);
      if (k > hold && c < vlen) begin
        st_valid = 1'b1;
        st_data = alt ? ~pat(ea) : pat(ea);
      end else begin
        st_valid = 1'b0;
      end
      #2;
      if (k <= hold) begin
        chk(!st_ready, "R10 no accept without data", 64'(st_ready), 0);
        chk(!done, "R10 no done while held", 64'(done), 0);
      end
      if (st_ready) begin
        exp_mem[ea] = st_data;
        c++;
      end
      if (done) done_k = k;
      else begin
        k++;
        @(negedge clk);
      end
    end
    st_valid = 1'b0;
    chk(done_k == exp_tot, "R9 store done cycle", 64'(done_k), 64'(exp_tot));
    chk(c == vlen, "R10 store beats", 64'(c), 64'(vlen));
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_indexed = 1'b0; cmd_store = 1'b0;
    cmd_base = '0; cmd_stride = '0; cmd_vlen = '0;
    idx_valid = 1'b0; idx_data = '0; st_valid = 1'b0; st_data = '0;
    for (int a = 0; a < 256; a++) exp_mem[a] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 reset cmd_ready", 64'(cmd_ready), 1);
    chk(rd_valid == 1'b0, "R1 reset rd_valid", 64'(rd_valid), 0);
    chk(done == 1'b0, "R1 reset done", 64'(done), 0);
    chk(stall == 1'b0, "R1 reset stall", 64'(stall), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 idle after reset", 64'(cmd_ready), 1);

    // R10: preload all 256 words with unit-stride stores
    for (int q = 0; q < 4; q++) do_store(q * 64, 1, 64, 0, 1'b0, 65);

    // Table of strided loads
    for (int i = 0; i < 9; i++)
      do_load(1'b0, int'(LTAB[i].base), int'(LTAB[i].stride), int'(LTAB[i].vlen),
              int'(LTAB[i].tot), int'(LTAB[i].stalls));

    // R6: indexed gather with bank conflicts (banks 8,11,8,8,3,2)
    idx_list[0] = 5;  idx_list[1] = 200; idx_list[2] = 21;
    idx_list[3] = 37; idx_list[4] = 0;   idx_list[5] = 255;
    do_load(1'b1, 3, 0, 6, 24, 5);

    // R8: zero length
    do_load(1'b0, 0, 1, 0, 1, 0);

    // R10: store held five cycles without data, then read back
    do_store(64, 1, 2, 5, 1'b1, 8);
    do_load(1'b0, 64, 1, 2, 15, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule